// File: doc/BRIEF.md
# Fault-Aware Link Remapping Controller

This controller sits between the data distributors of a network interface and the queues that hold outgoing traffic from the processing element. It decides which outgoing serial link carries which queue's traffic. A fault vector, with one bit per link, and an active-queue mask drive the decision. The controller keeps one map entry per link, made of a queue index and a valid bit. Distributors read the map and send a queue's words only on links whose entry is valid and names that queue.

When either input changes, the controller snapshots both inputs and clears every map entry. It then rebuilds the map, one link per clock cycle, in increasing link index. Each healthy link goes to the next active queue in turn, so the healthy links are spread over the active queues as evenly as possible. Losing a link therefore costs bandwidth rather than connectivity.

While a rebuild runs, a busy flag is high and dispatch of new words is withheld. Words already handed to the serial links finish on their own, outside this block. If every link is faulty, an error flag is raised and the map stays empty.

Top module: `link_remap_ctrl`

## Requirements
- R1: After reset every map entry is invalid with queue index 0, busy is low, the all-faulty flag is low and dispatch is permitted.
- R2: A change of the fault vector raises busy at the first rising clock edge after the change.
- R3: Each rebuild holds busy high for exactly NUM_LINKS consecutive cycles (8 by default), after which the map is final.
- R4: Healthy links are assigned in increasing link index, starting at the lowest-numbered active queue and moving cyclically to the next higher active queue after each assignment.
- R5: After a rebuild, the numbers of links assigned to any two active queues differ by at most one.
- R6: A link whose fault bit is set has its valid bit cleared and its queue index at 0.
- R7: When all fault bits are set, the all-faulty flag is high and no map entry is valid.
- R8: Dispatch-permit is low whenever busy is high or the all-faulty flag is high.
- R9: A change of the active-queue mask alone also starts a rebuild.
- R10: With an empty active-queue mask, every map entry is invalid after the rebuild.
- R11: An input change that arrives while a rebuild runs starts a further rebuild after the current one ends, so the final map reflects the latest inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| link_fault_i | input | NUM_LINKS | Fault flag per link, 1 = faulty |
| queue_act_i | input | NUM_QUEUES | Active flag per queue |
| map_qid_o | output | NUM_LINKS*QID_W | Queue index per link; link k occupies bits [k*QID_W +: QID_W] (QID_W = 2 by default) |
| map_vld_o | output | NUM_LINKS | Map entry valid per link |
| busy_o | output | 1 | A rebuild is in progress |
| all_fault_o | output | 1 | Every link is reported faulty |
| dispatch_ok_o | output | 1 | Distributors may hand out new words |

## Verification
A stuck or misrouted round-robin pointer shows as queue indices that skip or repeat on the links. The bench can read this from the map as soon as busy falls, NUM_LINKS cycles after the input change. A walker that stops early or runs on shows as a busy window of the wrong length, which can be seen cycle by cycle. A snapshot that misses an input change leaves a stale map, including a valid bit on a faulty link, once the rebuild should have ended. The bench checks these against entries it computes itself from the requirements.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
   typedef enum logic {
      WALK_IDLE = 1'b0,
      WALK_RUN  = 1'b1
   } walk_state_t;
endpackage

// File: rtl/lrc_qsel.sv
// Finds the lowest active queue and the next active queue after a given one.
module lrc_qsel #(
   parameter int NUM_QUEUES = 3,
   parameter int QID_W      = 2
) (
   input  logic [NUM_QUEUES-1:0] mask_i,
   input  logic [QID_W-1:0]      cur_i,
   output logic [QID_W-1:0]      first_o,
   output logic [QID_W-1:0]      next_o,
   output logic                  any_o
);
   always_comb begin
      logic found;
      first_o = '0;
      found   = 1'b0;
      for (int q = 0; q < NUM_QUEUES; q++) begin
         if (!found && mask_i[q]) begin
            first_o = QID_W'(q);
            found   = 1'b1;
         end
      end
   end

   always_comb begin
      logic found;
      int   cand;
      next_o = cur_i;
      found  = 1'b0;
      for (int k = 1; k <= NUM_QUEUES; k++) begin
         cand = (int'(cur_i) + k) % NUM_QUEUES;
         if (!found && mask_i[cand]) begin
            next_o = QID_W'(cand);
            found  = 1'b1;
         end
      end
   end

   assign any_o = |mask_i;
endmodule

// File: rtl/lrc_change_det.sv
// Snapshots the inputs and issues a start pulse when they differ from the snapshot.
module lrc_change_det #(
   parameter int NUM_LINKS  = 8,
   parameter int NUM_QUEUES = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_LINKS-1:0]  fault_i,
   input  logic [NUM_QUEUES-1:0] qact_i,
   input  logic                  busy_i,
   output logic [NUM_LINKS-1:0]  snap_fault_o,
   output logic [NUM_QUEUES-1:0] snap_qact_o,
   output logic                  start_o
);
   logic differs;

   assign differs = (fault_i != snap_fault_o) || (qact_i != snap_qact_o);
   assign start_o = differs && !busy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_fault_o <= '0;
         snap_qact_o  <= '0;
      end else if (start_o) begin
         snap_fault_o <= fault_i;
         snap_qact_o  <= qact_i;
      end
   end

   // R2: a start pulse is followed by busy
   p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> busy_i);
   // R11: a pending difference is taken up once busy falls
   p_pending_taken_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (differs && !busy_i) |=> (snap_fault_o == $past(fault_i)) && (snap_qact_o == $past(qact_i)));
endmodule

// File: rtl/lrc_walker.sv
// Visits one link per cycle and hands out healthy links round robin.
module lrc_walker
   import lrc_pkg::*;
#(
   parameter int NUM_LINKS  = 8,
   parameter int NUM_QUEUES = 3,
   parameter int QID_W      = 2,
   parameter int IDX_W      = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic [NUM_QUEUES-1:0] qact_now_i,
   input  logic [NUM_LINKS-1:0]  snap_fault_i,
   input  logic [NUM_QUEUES-1:0] snap_qact_i,
   output logic                  busy_o,
   output logic                  clr_all_o,
   output logic                  wr_en_o,
   output logic [IDX_W-1:0]      wr_idx_o,
   output logic                  wr_vld_o,
   output logic [QID_W-1:0]      wr_qid_o
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINKS - 1);

   walk_state_t      state;
   logic [IDX_W-1:0] idx;
   logic [QID_W-1:0] ptr;
   logic [QID_W-1:0] first_now, first_unused, next_ptr, next_unused;
   logic             any_now, any_snap;

   lrc_qsel #(.NUM_QUEUES(NUM_QUEUES), .QID_W(QID_W)) u_sel_first (
      .mask_i (qact_now_i),
      .cur_i  ('0),
      .first_o(first_now),
      .next_o (next_unused),
      .any_o  (any_now)
   );

   lrc_qsel #(.NUM_QUEUES(NUM_QUEUES), .QID_W(QID_W)) u_sel_next (
      .mask_i (snap_qact_i),
      .cur_i  (ptr),
      .first_o(first_unused),
      .next_o (next_ptr),
      .any_o  (any_snap)
   );

   assign busy_o    = (state == WALK_RUN);
   assign clr_all_o = start_i;
   assign wr_en_o   = busy_o;
   assign wr_idx_o  = idx;
   assign wr_vld_o  = busy_o && !snap_fault_i[idx] && any_snap;
   assign wr_qid_o  = wr_vld_o ? ptr : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= WALK_IDLE;
         idx   <= '0;
         ptr   <= '0;
      end else begin
         case (state)
            WALK_IDLE: begin
               if (start_i) begin
                  state <= WALK_RUN;
                  idx   <= '0;
                  ptr   <= any_now ? first_now : '0;
               end
            end
            WALK_RUN: begin
               if (wr_vld_o) ptr <= next_ptr;
               if (idx == LAST_IDX) begin
                  state <= WALK_IDLE;
                  idx   <= '0;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            default: state <= WALK_IDLE;
         endcase
      end
   end

   // R4: a written entry always names a queue from the active snapshot
   p_qid_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && wr_vld_o) |-> snap_qact_i[wr_qid_o]);
   // R6: a faulty link is never written valid
   p_no_fault_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && snap_fault_i[wr_idx_o]) |-> !wr_vld_o);
endmodule

// File: rtl/link_remap_ctrl.sv
// Fault-aware remapping of serial links onto active queues.
module link_remap_ctrl #(
   parameter int NUM_LINKS  = 8,
   parameter int NUM_QUEUES = 3,
   parameter int QID_W      = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_LINKS-1:0]        link_fault_i,
   input  logic [NUM_QUEUES-1:0]       queue_act_i,
   output logic [NUM_LINKS*QID_W-1:0]  map_qid_o,
   output logic [NUM_LINKS-1:0]        map_vld_o,
   output logic                        busy_o,
   output logic                        all_fault_o,
   output logic                        dispatch_ok_o
);
   localparam int IDX_W = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1;
   localparam int CNT_W = IDX_W + 1;

   generate
      if (NUM_LINKS < 2)        begin : g_chk_links  $error("NUM_LINKS must be at least 2"); end
      if (NUM_QUEUES < 2)       begin : g_chk_queues $error("NUM_QUEUES must be at least 2"); end
      if ((1 << QID_W) < NUM_QUEUES) begin : g_chk_qidw $error("QID_W too narrow"); end
   endgenerate

   logic [NUM_LINKS-1:0]  snap_fault;
   logic [NUM_QUEUES-1:0] snap_qact;
   logic                  start, clr_all, wr_en, wr_vld;
   logic [IDX_W-1:0]      wr_idx;
   logic [QID_W-1:0]      wr_qid;

   lrc_change_det #(.NUM_LINKS(NUM_LINKS), .NUM_QUEUES(NUM_QUEUES)) u_det (
      .clk         (clk),
      .rst_n       (rst_n),
      .fault_i     (link_fault_i),
      .qact_i      (queue_act_i),
      .busy_i      (busy_o),
      .snap_fault_o(snap_fault),
      .snap_qact_o (snap_qact),
      .start_o     (start)
   );

   lrc_walker #(.NUM_LINKS(NUM_LINKS), .NUM_QUEUES(NUM_QUEUES),
                .QID_W(QID_W), .IDX_W(IDX_W)) u_walk (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .qact_now_i  (queue_act_i),
      .snap_fault_i(snap_fault),
      .snap_qact_i (snap_qact),
      .busy_o      (busy_o),
      .clr_all_o   (clr_all),
      .wr_en_o     (wr_en),
      .wr_idx_o    (wr_idx),
      .wr_vld_o    (wr_vld),
      .wr_qid_o    (wr_qid)
   );

   generate
      for (genvar g = 0; g < NUM_LINKS; g++) begin : g_entry
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               map_vld_o[g]                 <= 1'b0;
               map_qid_o[g*QID_W +: QID_W]  <= '0;
            end else if (clr_all) begin
               map_vld_o[g]                 <= 1'b0;
               map_qid_o[g*QID_W +: QID_W]  <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
               map_vld_o[g]                 <= wr_vld;
               map_qid_o[g*QID_W +: QID_W]  <= wr_qid;
            end
         end
      end
   endgenerate

   assign all_fault_o   = &snap_fault;
   assign dispatch_ok_o = !busy_o && !all_fault_o;

   // busy-window length watch
   logic [CNT_W-1:0] busy_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      busy_cnt <= '0;
      else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
      else             busy_cnt <= '0;
   end

   // R3: busy never outlasts one pass over the links
   p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy_cnt <= CNT_W'(NUM_LINKS));
   // R3: a rebuild never ends early
   p_busy_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_cnt != '0 && busy_cnt < CNT_W'(NUM_LINKS)) |-> busy_o);
   // R6: no valid entry on a faulty link in the snapshot
   p_fault_unmapped_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (map_vld_o & snap_fault) == '0);
   // R7: all faulty means an empty map
   p_allfault_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      all_fault_o |-> (map_vld_o == '0));
   // R8: no dispatch during a rebuild
   p_dispatch_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !dispatch_ok_o);
endmodule

// File: tb/link_remap_ctrl_tb.sv
module link_remap_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NL = 8;
   localparam int NQ = 3;
   localparam int QW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] fault = '0;
   logic [NQ-1:0] qact = '0;
   logic [NL*QW-1:0] map_qid;
   logic [NL-1:0] map_vld;
   logic          busy, all_fault, disp_ok;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   link_remap_ctrl #(.NUM_LINKS(NL), .NUM_QUEUES(NQ)) u_dut (
      .clk(clk), .rst_n(rst_n), .link_fault_i(fault), .queue_act_i(qact),
      .map_qid_o(map_qid), .map_vld_o(map_vld), .busy_o(busy),
      .all_fault_o(all_fault), .dispatch_ok_o(disp_ok)
   );

   task automatic chk(input string req, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // expected map from R4/R6/R10
   task automatic check_map(input string req, input logic [NL-1:0] f, input logic [NQ-1:0] q);
      int ptr = 0;
      int cnt[NQ];
      int mx = 0, mn = NL;
      logic [NL-1:0] ev = '0;
      logic [NL*QW-1:0] eq = '0;
      for (int k = 0; k < NQ; k++) cnt[k] = 0;
      for (int k = NQ-1; k >= 0; k--) if (q[k]) ptr = k;
      for (int l = 0; l < NL; l++) begin
         if (!f[l] && q != '0) begin
            ev[l] = 1'b1;
            eq[l*QW +: QW] = QW'(ptr);
            for (int s = 1; s <= NQ; s++)
               if (q[(ptr+s)%NQ]) begin ptr = (ptr+s)%NQ; break; end
         end
      end
      chk(req, int'(map_vld), int'(ev), "valid bits");
      chk(req, int'(map_qid), int'(eq), "queue indices");
      // R5: balance over active queues, measured from the outputs
      for (int l = 0; l < NL; l++) if (map_vld[l]) cnt[map_qid[l*QW +: QW]]++;
      for (int k = 0; k < NQ; k++) if (q[k]) begin
         if (cnt[k] > mx) mx = cnt[k];
         if (cnt[k] < mn) mn = cnt[k];
      end
      if (q != '0 && f != '1) chk("R5", int'(mx - mn <= 1), 1, "balance spread");
   endtask

   // applies inputs, checks busy rise and busy length
   task automatic apply(input string req, input logic [NL-1:0] f, input logic [NQ-1:0] q);
      int n = 0;
      @(negedge clk);
      fault = f; qact = q;
      @(negedge clk);
      chk(req, int'(busy), 1, "busy after change (R2)");
      chk("R8", int'(disp_ok), 0, "dispatch while busy");
      while (busy && n < 50) begin n++; @(negedge clk); end
      chk("R3", n, NL, "busy cycles");
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1", int'(map_vld), 0, "reset valid");
      chk("R1", int'(map_qid), 0, "reset qid");
      chk("R1", int'(busy), 0, "reset busy");
      chk("R1", int'(all_fault), 0, "reset all_fault");
      chk("R1", int'(disp_ok), 1, "reset dispatch");
   endtask

   task automatic t_all_healthy();
      apply("R2", 8'h00, 3'b111);
      check_map("R4", 8'h00, 3'b111);
      chk("R8", int'(disp_ok), 1, "dispatch after rebuild");
   endtask

   task automatic t_one_fault();
      apply("R2", 8'h04, 3'b111);
      check_map("R6", 8'h04, 3'b111);
   endtask

   task automatic t_queue_change();
      apply("R9", 8'h04, 3'b101);
      check_map("R9", 8'h04, 3'b101);
      apply("R9", 8'h31, 3'b110);
      check_map("R4", 8'h31, 3'b110);
   endtask

   task automatic t_all_faulty();
      apply("R2", 8'hFF, 3'b111);
      check_map("R7", 8'hFF, 3'b111);
      chk("R7", int'(all_fault), 1, "all_fault flag");
      chk("R8", int'(disp_ok), 0, "dispatch when all faulty");
   endtask

   task automatic t_no_queues();
      apply("R10", 8'h00, 3'b000);
      check_map("R10", 8'h00, 3'b000);
      chk("R7", int'(all_fault), 0, "all_fault clear");
   endtask

   task automatic t_change_midway();
      @(negedge clk);
      fault = 8'h00; qact = 3'b111;
      repeat (3) @(negedge clk);
      fault = 8'h81; qact = 3'b011;
      repeat (30) @(negedge clk);
      chk("R11", int'(busy), 0, "busy settled");
      check_map("R11", 8'h81, 3'b011);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_all_healthy();
      t_one_fault();
      t_queue_change();
      t_all_faulty();
      t_no_queues();
      t_change_midway();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule